// File: doc/BRIEF.md
# Bus Width and Byte Lane Steering Unit

This unit sits between a host bus interface and the storage of a peripheral (a packet RAM and a small register file). For every access it decides whether the transfer is one byte or one word. It drives the two active-low "16-bit target" indications that a host bus samples early in a cycle: one for memory space and one for I/O space. It also enables the output drivers of the low and high data-bus bytes on reads and produces one-cycle byte-write strobes toward the RAM or the registers on writes.

A global configuration bit selects byte-wide or word-wide operation. In word-wide operation the wide path is granted per target. RAM reached through memory space and the two I/O registers that move bulk data (the address pointer and the data port) use both byte lanes. Every other register stays one byte wide and uses only the low lane. Address decoding into a select, a space flag and a register identifier is done outside the unit. The unit holds no storage apart from one flag that finds the start of a write strobe.

Top module: `lane_steer`

## Requirements
- R1: When the configuration bit `cfg_wide` is 0, `mem_cs16_n` and `io_cs16_n` both stay 1 for every access.
- R2: When `cfg_wide` is 0, `hi_oe` stays 0, and a selected read drives only `lo_oe`.
- R3: When `cfg_wide` is 1, `mem_cs16_n` is 0 exactly when `dev_sel` is 1 and `mem_space` is 1 (a RAM access in memory space). This does not depend on the strobes.
- R4: When `cfg_wide` is 1, `io_cs16_n` is 0 exactly when `dev_sel` is 1, `mem_space` is 0 and `reg_id` equals the pointer code (default 4'hA) or the data-port code (default 4'hC).
- R5: When `cfg_wide` is 1, an I/O access to any other `reg_id` is byte wide. A read drives `lo_oe` only, and a write pulses `reg_we` bit 0 only.
- R6: When `cfg_wide` is 1, a read of RAM, the pointer or the data port drives both `lo_oe` and `hi_oe`. A write pulses both write-enable bits, `a0` is ignored and `swap_odd` stays 0.
- R7: When `dev_sel` is 0, both CS16 outputs are 1 and every output enable and write enable is 0.
- R8: The output enables are 1 only while `rd_stb` is 1. A write access drives neither byte lane.
- R9: A write pulses its enables for exactly one clock cycle, in the first cycle that `wr_stb` is seen high. They stay 0 while the strobe is held.
- R10: Writes to RAM (memory space) and to the data port go to `ram_we`. Writes to the pointer and to all other registers go to `reg_we`. The two are never non-zero together.
- R11: When `cfg_wide` is 0 and the target is RAM, the pointer or the data port, `a0` selects the storage byte. With `a0`=0 the write uses enable bit 0 and `swap_odd` is 0. With `a0`=1 the write uses bit 1 and `swap_odd` is 1. Narrow registers always use bit 0 and keep `swap_odd` at 0.
- R12: While `rst` is 1 no write enable is driven. A `wr_stb` that is already high when reset is released produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | 1 = word-wide operation, 0 = byte-wide |
| mem_space | input | 1 | 1 = access in memory space (RAM), 0 = I/O space |
| dev_sel | input | 1 | Peripheral selected by the external decoder |
| reg_id | input | ID_W | Decoded register identifier for I/O accesses |
| a0 | input | 1 | Byte address bit, used for byte accesses to word storage |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| mem_cs16_n | output | 1 | Memory-space 16-bit target indication, active low |
| io_cs16_n | output | 1 | I/O-space 16-bit target indication, active low |
| lo_oe | output | 1 | Drive enable, data bits 7:0 |
| hi_oe | output | 1 | Drive enable, data bits 15:8 |
| swap_odd | output | 1 | Route the odd storage byte onto the low bus lane |
| ram_we | output | 2 | Byte-write strobes toward RAM (bit 1 = odd byte) |
| reg_we | output | 2 | Byte-write strobes toward registers (bit 1 = high byte) |

## Verification
Every target class (memory-space RAM, pointer, data port, an ordinary register) is accessed in both bus widths, for read and for write, and with both values of `a0`. This separates a per-target grant from a per-mode one and shows whether `a0` matters only for byte accesses to word storage. Accesses with `dev_sel` low and mixed other inputs show that nothing leaks out when the unit is not addressed. Write strobes held for several cycles, and one held across reset release, separate edge-based pulsing from level-based pulsing.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        TGT_RAM    = 2'd0,
        TGT_PTR    = 2'd1,
        TGT_DATA   = 2'd2,
        TGT_NARROW = 2'd3
    } tgt_e;

    typedef logic [LANES-1:0] lanes_t;

    typedef struct packed {
        logic sel;
        tgt_e tgt;
        logic full;
    } cls_t;

    // Word storage targets may be reached as single bytes or as a word.
    function automatic logic is_word_store(input tgt_e t);
        return t != TGT_NARROW;
    endfunction

    // Targets whose writes land in the RAM array.
    function automatic logic goes_to_ram(input tgt_e t);
        return (t == TGT_RAM) || (t == TGT_DATA);
    endfunction

    // Storage byte lanes touched by an access.
    function automatic lanes_t store_lanes(input cls_t c, input logic odd);
        lanes_t l;
        l = '0;
        if (c.sel) begin
            if (c.full)
                l = '1;
            else if (is_word_store(c.tgt))
                l[odd] = 1'b1;
            else
                l[0] = 1'b1;
        end
        return l;
    endfunction

    // Bus byte lanes driven by an access.
    function automatic lanes_t bus_lanes(input cls_t c);
        lanes_t l;
        l = '0;
        if (c.sel) begin
            l[0] = 1'b1;
            if (c.full)
                l = '1;
        end
        return l;
    endfunction

endpackage

// File: rtl/lane_classify.sv
module lane_classify
    import lane_pkg::*;
#(
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] ID_PTR  = 4'hA,
    parameter logic [ID_W-1:0] ID_DATA = 4'hC
) (
    input  logic            cfg_wide,
    input  logic            mem_space,
    input  logic            dev_sel,
    input  logic [ID_W-1:0] reg_id,
    output cls_t            cls
);

    tgt_e tgt;

    always_comb begin
        if (mem_space)
            tgt = TGT_RAM;
        else if (reg_id == ID_PTR)
            tgt = TGT_PTR;
        else if (reg_id == ID_DATA)
            tgt = TGT_DATA;
        else
            tgt = TGT_NARROW;
    end

    always_comb begin
        cls.sel  = dev_sel;
        cls.tgt  = tgt;
        cls.full = dev_sel & cfg_wide & is_word_store(tgt);
    end

endmodule

// File: rtl/lane_cs16.sv
module lane_cs16
    import lane_pkg::*;
(
    input  cls_t cls,
    output logic mem_cs16_n,
    output logic io_cs16_n
);

    logic mem_grant;
    logic io_grant;

    always_comb begin
        mem_grant = cls.full & (cls.tgt == TGT_RAM);
        io_grant  = cls.full & ((cls.tgt == TGT_PTR) | (cls.tgt == TGT_DATA));
        mem_cs16_n = ~mem_grant;
        io_cs16_n  = ~io_grant;
    end

endmodule

// File: rtl/lane_strobe.sv
module lane_strobe
    import lane_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cls_t   cls,
    input  logic   a0,
    input  logic   rd_stb,
    input  logic   wr_stb,
    output lanes_t bus_oe,
    output lanes_t ram_we,
    output lanes_t reg_we,
    output logic   swap_odd
);

    logic   wr_seen;
    logic   wr_pulse;
    logic   to_ram;
    lanes_t st_lanes;
    lanes_t bs_lanes;

    // Reset to "already seen" so a strobe held over reset release is ignored.
    always_ff @(posedge clk) begin
        if (rst)
            wr_seen <= 1'b1;
        else
            wr_seen <= wr_stb;
    end

    always_comb begin
        wr_pulse = wr_stb & ~wr_seen & ~rst;
        to_ram   = goes_to_ram(cls.tgt);
        st_lanes = store_lanes(cls, a0);
        bs_lanes = bus_lanes(cls);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            bus_oe[g] = rd_stb & bs_lanes[g];
            ram_we[g] = wr_pulse & to_ram & st_lanes[g];
            reg_we[g] = wr_pulse & ~to_ram & st_lanes[g];
        end
    end

    always_comb begin
        swap_odd = cls.sel & ~cls.full & is_word_store(cls.tgt) & a0;
    end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_pkg::*;
#(
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] ID_PTR  = 4'hA,
    parameter logic [ID_W-1:0] ID_DATA = 4'hC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wide,
    input  logic            mem_space,
    input  logic            dev_sel,
    input  logic [ID_W-1:0] reg_id,
    input  logic            a0,
    input  logic            rd_stb,
    input  logic            wr_stb,
    output logic            mem_cs16_n,
    output logic            io_cs16_n,
    output logic            lo_oe,
    output logic            hi_oe,
    output logic            swap_odd,
    output logic [1:0]      ram_we,
    output logic [1:0]      reg_we
);

    cls_t   cls;
    lanes_t bus_oe;
    lanes_t ram_we_l;
    lanes_t reg_we_l;

    lane_classify #(
        .ID_W   (ID_W),
        .ID_PTR (ID_PTR),
        .ID_DATA(ID_DATA)
    ) u_cls (
        .cfg_wide (cfg_wide),
        .mem_space(mem_space),
        .dev_sel  (dev_sel),
        .reg_id   (reg_id),
        .cls      (cls)
    );

    lane_cs16 u_cs (
        .cls       (cls),
        .mem_cs16_n(mem_cs16_n),
        .io_cs16_n (io_cs16_n)
    );

    lane_strobe u_stb (
        .clk     (clk),
        .rst     (rst),
        .cls     (cls),
        .a0      (a0),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .bus_oe  (bus_oe),
        .ram_we  (ram_we_l),
        .reg_we  (reg_we_l),
        .swap_odd(swap_odd)
    );

    assign lo_oe  = bus_oe[0];
    assign hi_oe  = bus_oe[1];
    assign ram_we = ram_we_l;
    assign reg_we = reg_we_l;

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] ID_PTR  = 4'hA,
    parameter logic [ID_W-1:0] ID_DATA = 4'hC
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_wide,
    input logic            mem_space,
    input logic            dev_sel,
    input logic [ID_W-1:0] reg_id,
    input logic            a0,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic            mem_cs16_n,
    input logic            io_cs16_n,
    input logic            lo_oe,
    input logic            hi_oe,
    input logic            swap_odd,
    input logic [1:0]      ram_we,
    input logic [1:0]      reg_we
);

    logic narrow_reg;
    assign narrow_reg = !mem_space && (reg_id != ID_PTR) && (reg_id != ID_DATA);

    p_narrow_no_cs_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_wide |-> (mem_cs16_n && io_cs16_n));

    p_narrow_no_hi_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_wide |-> !hi_oe);

    p_mem_cs_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_wide |-> (mem_cs16_n == !(dev_sel && mem_space)));

    p_io_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wide && dev_sel && !mem_space && !narrow_reg) |-> !io_cs16_n);

    p_small_reg_r5: assert property (@(posedge clk) disable iff (rst)
        (dev_sel && narrow_reg) |-> (io_cs16_n && !hi_oe && !reg_we[1]));

    p_word_read_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wide && dev_sel && rd_stb && !narrow_reg) |-> (lo_oe && hi_oe && !swap_odd));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !dev_sel |-> (mem_cs16_n && io_cs16_n && !lo_oe && !hi_oe
                      && ram_we == 2'b00 && reg_we == 2'b00));

    p_oe_on_read_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (!lo_oe && !hi_oe));

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ((ram_we != 2'b00) || (reg_we != 2'b00)) |=> (ram_we == 2'b00 && reg_we == 2'b00));

    p_one_dest_r10: assert property (@(posedge clk) disable iff (rst)
        (ram_we != 2'b00) |-> (reg_we == 2'b00));

    p_byte_store_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_wide |-> ($countones(ram_we) <= 1 && $countones(reg_we) <= 1));

    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |-> (ram_we == 2'b00 && reg_we == 2'b00));

endmodule

bind lane_steer lane_steer_chk #(
    .ID_W   (ID_W),
    .ID_PTR (ID_PTR),
    .ID_DATA(ID_DATA)
) u_chk (.*);

// File: tb/lane_steer_test.sv
`timescale 1ns/1ps
module lane_steer_test;

    localparam logic [3:0] PTR  = 4'hA;
    localparam logic [3:0] DATA = 4'hC;
    localparam logic [3:0] SMALL = 4'h3;

    typedef struct {
        logic       mcs_n;
        logic       ics_n;
        logic       lo;
        logic       hi;
        logic       swp;
        logic [1:0] rw;
        logic [1:0] gw;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wide = 1'b0, mem_space = 1'b0, dev_sel = 1'b0;
    logic [3:0] reg_id = 4'h0;
    logic a0 = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic mem_cs16_n, io_cs16_n, lo_oe, hi_oe, swap_odd;
    logic [1:0] ram_we, reg_we;

    int checks = 0;
    int fails = 0;
    exp_t sb[$];
    logic prev_wr = 1'b0;
    logic prev_rst = 1'b1;
    bit done = 0;

    always #5 clk = ~clk;

    lane_steer uut (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .mem_space(mem_space),
        .dev_sel(dev_sel), .reg_id(reg_id), .a0(a0), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .mem_cs16_n(mem_cs16_n), .io_cs16_n(io_cs16_n),
        .lo_oe(lo_oe), .hi_oe(hi_oe), .swap_odd(swap_odd),
        .ram_we(ram_we), .reg_we(reg_we)
    );

    // Driver: applies one access per cycle and predicts the outputs.
    task automatic cyc(input logic r, input logic w16, input logic ms, input logic sel,
                       input logic [3:0] id, input logic odd, input logic rd,
                       input logic wr, input string tag);
        exp_t e;
        logic ram_t, ptr_t, dat_t, word_t, full, first;
        logic [1:0] st;
        @(negedge clk);
        rst = r; cfg_wide = w16; mem_space = ms; dev_sel = sel;
        reg_id = id; a0 = odd; rd_stb = rd; wr_stb = wr;
        ram_t  = ms;
        ptr_t  = !ms && id == PTR;
        dat_t  = !ms && id == DATA;
        word_t = ram_t | ptr_t | dat_t;
        full   = sel & w16 & word_t;
        first  = wr & !r & !(prev_rst | prev_wr);
        e.mcs_n = !(full & ram_t);
        e.ics_n = !(full & (ptr_t | dat_t));
        e.lo    = rd & sel;
        e.hi    = rd & full;
        e.swp   = sel & !full & word_t & odd;
        if (!sel)        st = 2'b00;
        else if (full)   st = 2'b11;
        else if (word_t) st = odd ? 2'b10 : 2'b01;
        else             st = 2'b01;
        e.rw  = (first && (ram_t | dat_t)) ? st : 2'b00;
        e.gw  = (first && !(ram_t | dat_t)) ? st : 2'b00;
        e.tag = tag;
        sb.push_back(e);
        prev_wr  = wr;
        prev_rst = r;
    endtask

    // Monitor: compares the design's outputs against the oldest prediction.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (mem_cs16_n !== e.mcs_n || io_cs16_n !== e.ics_n || lo_oe !== e.lo ||
                    hi_oe !== e.hi || swap_odd !== e.swp || ram_we !== e.rw ||
                    reg_we !== e.gw) begin
                    fails++;
                    $display("FAIL %s: got mcs=%b ics=%b lo=%b hi=%b swp=%b ram=%b reg=%b exp mcs=%b ics=%b lo=%b hi=%b swp=%b ram=%b reg=%b",
                             e.tag, mem_cs16_n, io_cs16_n, lo_oe, hi_oe, swap_odd, ram_we, reg_we,
                             e.mcs_n, e.ics_n, e.lo, e.hi, e.swp, e.rw, e.gw);
                end
            end
        end
    end

    task automatic wr_access(input logic w16, input logic ms, input logic [3:0] id,
                             input logic odd, input string tag);
        cyc(0, w16, ms, 1, id, odd, 0, 0, tag);
        cyc(0, w16, ms, 1, id, odd, 0, 1, tag);
        cyc(0, w16, ms, 1, id, odd, 0, 1, {tag, " R9 hold"});
        cyc(0, w16, ms, 1, id, odd, 0, 0, tag);
    endtask

    initial begin
        // R12: reset state and strobe held across reset release
        cyc(1, 0, 0, 0, 4'h0, 0, 0, 0, "R12 reset idle");
        cyc(1, 1, 1, 1, 4'h0, 0, 0, 1, "R12 write during reset");
        cyc(0, 1, 1, 1, 4'h0, 0, 0, 1, "R12 held strobe after release");
        cyc(0, 1, 1, 1, 4'h0, 0, 0, 1, "R12 still held");
        cyc(0, 0, 0, 0, 4'h0, 0, 0, 0, "R7 idle");

        // Byte-wide mode (R1, R2, R11)
        cyc(0, 0, 1, 1, 4'h0, 0, 1, 0, "R1 R2 ram read even");
        cyc(0, 0, 1, 1, 4'h0, 1, 1, 0, "R11 ram read odd");
        cyc(0, 0, 0, 1, PTR,  1, 1, 0, "R1 ptr read odd");
        cyc(0, 0, 0, 1, DATA, 0, 1, 0, "R2 data read");
        cyc(0, 0, 0, 1, SMALL, 1, 1, 0, "R11 small reg odd read");
        wr_access(0, 1, 4'h0, 0, "R11 ram byte write even");
        wr_access(0, 1, 4'h0, 1, "R11 ram byte write odd");
        wr_access(0, 0, PTR,  1, "R10 ptr byte write odd");
        wr_access(0, 0, DATA, 1, "R10 data byte write odd");
        wr_access(0, 0, SMALL, 1, "R11 small reg write");

        // Word-wide mode (R3..R6, R8, R10)
        cyc(0, 1, 1, 1, 4'h0, 0, 0, 0, "R3 ram addressed no strobe");
        cyc(0, 1, 1, 1, 4'h0, 1, 1, 0, "R6 ram word read");
        cyc(0, 1, 0, 1, PTR,  0, 1, 0, "R4 ptr word read");
        cyc(0, 1, 0, 1, DATA, 1, 1, 0, "R4 data word read");
        cyc(0, 1, 0, 1, SMALL, 0, 1, 0, "R5 small reg read");
        cyc(0, 1, 0, 1, 4'h0, 0, 1, 0, "R5 reg id zero read");
        cyc(0, 1, 0, 1, PTR,  0, 0, 1, "R8 write drives no lane");
        cyc(0, 1, 0, 0, PTR,  0, 0, 0, "R7 gap");
        wr_access(1, 1, 4'h0, 1, "R6 ram word write");
        wr_access(1, 0, PTR,  1, "R10 ptr word write");
        wr_access(1, 0, DATA, 0, "R10 data word write");
        wr_access(1, 0, SMALL, 1, "R5 small reg write");

        // R7: unselected with mixed inputs
        cyc(0, 1, 1, 0, 4'h0, 1, 1, 0, "R7 ram unselected read");
        cyc(0, 1, 0, 0, DATA, 0, 0, 1, "R7 data unselected write");
        cyc(0, 1, 0, 0, DATA, 0, 0, 0, "R7 unselected idle");

        // R12: reset asserted mid-stream
        cyc(1, 1, 0, 1, PTR, 0, 0, 1, "R12 write in second reset");
        cyc(0, 1, 0, 1, PTR, 0, 0, 0, "R12 released");
        cyc(0, 1, 0, 1, PTR, 0, 0, 1, "R12 fresh strobe pulses");

        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        int cnt;
        cnt = 0;
        while (!done && cnt < 5000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule